// File: doc/BRIEF.md
# Quantized First-Order Recursive Filter

This block is a first-order recursive filter whose arithmetic is entirely signed fixed point. Each of its seven numeric nodes has its own integer and fractional bit count, fixed at elaboration. The nodes are the input sample, the three coefficients, the shared product node, the delay state and the output. Sweeping those parameters lets one netlist family cover many precision/area points. Two effects set the quality of each configuration: the floor rounding at every node and the clamping of overflowing values.

Samples arrive on a valid/ready stream and leave on a valid/ready stream. An input is taken on any clock edge where `in_valid` and `in_ready` are both high. The producer keeps `in_valid` high and `in_data` and the coefficient ports steady until that edge. An output is handed over on any edge where `out_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the output register keeps its value, and `in_ready` drops once the internal stage is also occupied. No sample is dropped or duplicated.

The filter computes y[n] = b0·x[n] + b1·x[n-1] − a1·y[n-1] in transposed direct form with a single state register. All three coefficients are sampled together with the input sample they apply to.

Top module: `fxq_iir1`

## Requirements
- R1: Every number is two's complement with total width = integer bits + fractional bits, and the integer bits include the sign. The formats are: `in_data` in input format (default 1 integer, 15 fraction), coefficient ports in coefficient format (default 2.14), and `out_data` in output format (default 2.12).
- R2: Requantizing to fewer fractional bits rounds toward negative infinity. For example, 25735 in 3.13 (about 3.14148) becomes 201 in 3.6 (011.001001 = 3.140625), and −25735 becomes −202.
- R3: A value outside the range of the target format saturates to the most positive (0111…1) or most negative (1000…0) code. For example, 25735 in 3.13 gives 127 in 2.6, and −25735 gives −128.
- R4: For each sample, the intermediate values are formed in this order:
  - Quantize x to the input node format, and each coefficient to its own node format.
  - p0 = q_P(x·b0) and p1 = q_P(x·b1).
  - y = q_Y(p0 + s).
  - s_next = q_S(p1 − q_P(a1·y)).
  - Each q floors and saturates, and each sum is formed exactly before it is quantized.
- R5: The values of `coef_b0`, `coef_b1` and `coef_a1` present on the accepting edge are the ones applied to that sample, even when they change from one sample to the next.
- R6: With `out_ready` high, a sample accepted on edge t appears with `out_valid` high after edge t+1 and not after edge t. Outputs follow inputs one for one and in order.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold on the next edge. Random back-pressure changes no output value.
- R8: Synchronous reset empties the pipeline (`out_valid` low, `in_ready` high) and clears the state to zero. The first sample after reset is therefore filtered from a zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | IN_I+IN_F | Input sample |
| coef_b0 | input | CF_I+CF_F | Feed-forward coefficient for the current sample |
| coef_b1 | input | CF_I+CF_F | Feed-forward coefficient for the delayed sample |
| coef_a1 | input | CF_I+CF_F | Feedback coefficient, subtracted |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_data | output | Y_I+Y_F | Filtered output sample |

## Verification
The handshake assertions assume the producer obeys the stream rule: `in_valid`, `in_data` and the coefficients stay put until accepted. The bench drives each pending sample from a pure function of its index, so a sample that waits is re-driven with identical values. The assertions also assume that reset is applied before the first sample, and the bench raises `rst` from time zero. The node formats are assumed to leave at least one bit after each floor, which the chosen defaults do. Stimulus is kept to complete 16-bit codes, including both extremes, so every value the ports can carry is legal.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
  function automatic int fxq_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fxq_requant.sv
module fxq_requant #(
  parameter int IN_I  = 3,
  parameter int IN_F  = 13,
  parameter int OUT_I = 3,
  parameter int OUT_F = 6
) (
  input  logic signed [IN_I+IN_F-1:0]   din,
  output logic signed [OUT_I+OUT_F-1:0] dout
);
  localparam int IN_W  = IN_I + IN_F;
  localparam int OUT_W = OUT_I + OUT_F;
  localparam int SH    = OUT_F - IN_F;
  localparam int AW    = IN_W + SH;

  logic signed [AW-1:0] aligned;

  generate
    if (SH >= 0) begin : g_up
      assign aligned = AW'(din) <<< SH;
    end else begin : g_down
      localparam int DROP = IN_F - OUT_F;
      // dropping low bits of a two's complement value is a floor
      assign aligned = din[IN_W-1:DROP];
    end

    if (AW > OUT_W) begin : g_sat
      logic [AW-OUT_W:0] head;
      assign head = aligned[AW-1:OUT_W-1];
      always_comb begin
        if ((&head) || !(|head))
          dout = aligned[OUT_W-1:0];
        else if (aligned[AW-1])
          dout = {1'b1, {(OUT_W-1){1'b0}}};
        else
          dout = {1'b0, {(OUT_W-1){1'b1}}};
      end
    end else begin : g_ext
      assign dout = OUT_W'(aligned);
    end
  endgenerate
endmodule

// File: rtl/fxq_mul.sv
module fxq_mul #(
  parameter int A_I = 1,
  parameter int A_F = 11,
  parameter int B_I = 2,
  parameter int B_F = 10,
  parameter int O_I = 3,
  parameter int O_F = 12
) (
  input  logic signed [A_I+A_F-1:0] a,
  input  logic signed [B_I+B_F-1:0] b,
  output logic signed [O_I+O_F-1:0] o
);
  localparam int PW = A_I + A_F + B_I + B_F;

  logic signed [PW-1:0] prod;
  assign prod = PW'(a) * PW'(b);

  fxq_requant #(
    .IN_I (A_I + B_I), .IN_F (A_F + B_F),
    .OUT_I(O_I),       .OUT_F(O_F)
  ) u_rq (
    .din (prod),
    .dout(o)
  );
endmodule

// File: rtl/fxq_add.sv
module fxq_add import fxq_pkg::*; #(
  parameter int A_I = 3,
  parameter int A_F = 12,
  parameter int B_I = 3,
  parameter int B_F = 12,
  parameter int O_I = 2,
  parameter int O_F = 12,
  parameter bit SUB = 1'b0
) (
  input  logic signed [A_I+A_F-1:0] a,
  input  logic signed [B_I+B_F-1:0] b,
  output logic signed [O_I+O_F-1:0] o
);
  localparam int C_F = fxq_max(A_F, B_F);
  localparam int C_I = fxq_max(A_I, B_I) + 1;
  localparam int C_W = C_I + C_F;

  logic signed [C_W-1:0] a_c, b_c, r;

  fxq_requant #(.IN_I(A_I), .IN_F(A_F), .OUT_I(C_I), .OUT_F(C_F))
    u_ala (.din(a), .dout(a_c));
  fxq_requant #(.IN_I(B_I), .IN_F(B_F), .OUT_I(C_I), .OUT_F(C_F))
    u_alb (.din(b), .dout(b_c));

  generate
    if (SUB) begin : g_sub
      assign r = a_c - b_c;
    end else begin : g_sum
      assign r = a_c + b_c;
    end
  endgenerate

  fxq_requant #(.IN_I(C_I), .IN_F(C_F), .OUT_I(O_I), .OUT_F(O_F))
    u_out (.din(r), .dout(o));
endmodule

// File: rtl/fxq_iir1.sv
module fxq_iir1 #(
  parameter int IN_I = 1,  parameter int IN_F = 15,
  parameter int CF_I = 2,  parameter int CF_F = 14,
  parameter int X_I  = 1,  parameter int X_F  = 11,
  parameter int B0_I = 2,  parameter int B0_F = 10,
  parameter int B1_I = 2,  parameter int B1_F = 10,
  parameter int A1_I = 1,  parameter int A1_F = 11,
  parameter int P_I  = 3,  parameter int P_F  = 12,
  parameter int S_I  = 3,  parameter int S_F  = 12,
  parameter int Y_I  = 2,  parameter int Y_F  = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic signed [IN_I+IN_F-1:0]  in_data,
  input  logic signed [CF_I+CF_F-1:0]  coef_b0,
  input  logic signed [CF_I+CF_F-1:0]  coef_b1,
  input  logic signed [CF_I+CF_F-1:0]  coef_a1,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic signed [Y_I+Y_F-1:0]    out_data
);
  localparam int X_W  = X_I + X_F;
  localparam int B0_W = B0_I + B0_F;
  localparam int B1_W = B1_I + B1_F;
  localparam int A1_W = A1_I + A1_F;
  localparam int P_W  = P_I + P_F;
  localparam int S_W  = S_I + S_F;
  localparam int Y_W  = Y_I + Y_F;

  // node quantization of the port values
  logic signed [X_W-1:0]  x_q;
  logic signed [B0_W-1:0] b0_q;
  logic signed [B1_W-1:0] b1_q;
  logic signed [A1_W-1:0] a1_q;

  fxq_requant #(.IN_I(IN_I), .IN_F(IN_F), .OUT_I(X_I), .OUT_F(X_F))
    u_qx  (.din(in_data), .dout(x_q));
  fxq_requant #(.IN_I(CF_I), .IN_F(CF_F), .OUT_I(B0_I), .OUT_F(B0_F))
    u_qb0 (.din(coef_b0), .dout(b0_q));
  fxq_requant #(.IN_I(CF_I), .IN_F(CF_F), .OUT_I(B1_I), .OUT_F(B1_F))
    u_qb1 (.din(coef_b1), .dout(b1_q));
  fxq_requant #(.IN_I(CF_I), .IN_F(CF_F), .OUT_I(A1_I), .OUT_F(A1_F))
    u_qa1 (.din(coef_a1), .dout(a1_q));

  // stage 1: feed-forward products
  logic signed [P_W-1:0] p0_w, p1_w;

  fxq_mul #(.A_I(X_I), .A_F(X_F), .B_I(B0_I), .B_F(B0_F), .O_I(P_I), .O_F(P_F))
    u_m0 (.a(x_q), .b(b0_q), .o(p0_w));
  fxq_mul #(.A_I(X_I), .A_F(X_F), .B_I(B1_I), .B_F(B1_F), .O_I(P_I), .O_F(P_F))
    u_m1 (.a(x_q), .b(b1_q), .o(p1_w));

  logic                   s1_v;
  logic signed [P_W-1:0]  p0_r, p1_r;
  logic signed [A1_W-1:0] a1_r;
  logic                   s1_ready, s2_ready, s1_take, s2_take;

  assign s2_ready = !out_valid || out_ready;
  assign s1_ready = !s1_v || s2_ready;
  assign in_ready = s1_ready;
  assign s1_take  = in_valid && s1_ready;
  assign s2_take  = s1_v && s2_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      p0_r <= '0;
      p1_r <= '0;
      a1_r <= '0;
    end else if (s1_ready) begin
      s1_v <= in_valid;
      if (in_valid) begin
        p0_r <= p0_w;
        p1_r <= p1_w;
        a1_r <= a1_q;
      end
    end
  end

  // stage 2: output sum and state update through the feedback path
  logic signed [S_W-1:0] s_r, s_next;
  logic signed [Y_W-1:0] y_next;
  logic signed [P_W-1:0] pfb;

  fxq_add #(.A_I(P_I), .A_F(P_F), .B_I(S_I), .B_F(S_F), .O_I(Y_I), .O_F(Y_F), .SUB(1'b0))
    u_ay (.a(p0_r), .b(s_r), .o(y_next));
  fxq_mul #(.A_I(A1_I), .A_F(A1_F), .B_I(Y_I), .B_F(Y_F), .O_I(P_I), .O_F(P_F))
    u_mfb (.a(a1_r), .b(y_next), .o(pfb));
  fxq_add #(.A_I(P_I), .A_F(P_F), .B_I(P_I), .B_F(P_F), .O_I(S_I), .O_F(S_F), .SUB(1'b1))
    u_as (.a(p1_r), .b(pfb), .o(s_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      s_r       <= '0;
    end else if (s2_take) begin
      out_valid <= 1'b1;
      out_data  <= y_next;
      s_r       <= s_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // samples held between the two stream edges
  logic [2:0] inflight;
  always_ff @(posedge clk) begin
    if (rst)
      inflight <= '0;
    else
      inflight <= inflight + {2'b00, s1_take} - {2'b00, (out_valid && out_ready)};
  end

  assert_reset_empty_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && s_r == '0 && inflight == '0))
    else $error("reset left pipeline or state non-empty");

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid)
    else $error("output dropped under back-pressure");

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data))
    else $error("output changed under back-pressure");

  assert_state_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !s2_take |=> $stable(s_r))
    else $error("state moved without a sample");

  assert_inflight_R6: assert property (@(posedge clk) disable iff (rst)
    inflight <= 3'd2)
    else $error("more than two samples in flight");

  assert_out_backed_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != 3'd0))
    else $error("output with no accepted sample");
endmodule

// File: tb/fxq_iir1_tb.sv
`timescale 1ns/1ps
module fxq_iir1_tb;
  localparam int IN_I = 1,  IN_F = 15, CF_I = 2, CF_F = 14;
  localparam int X_I  = 1,  X_F  = 11;
  localparam int B0_I = 2,  B0_F = 10, B1_I = 2, B1_F = 10;
  localparam int A1_I = 1,  A1_F = 11;
  localparam int P_I  = 3,  P_F  = 12, S_I = 3, S_F = 12;
  localparam int Y_I  = 2,  Y_F  = 12;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_data = '0;
  logic signed [15:0] coef_b0 = '0, coef_b1 = '0, coef_a1 = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [13:0] out_data;

  always #2 clk = ~clk;

  fxq_iir1 #(
    .IN_I(IN_I), .IN_F(IN_F), .CF_I(CF_I), .CF_F(CF_F), .X_I(X_I), .X_F(X_F),
    .B0_I(B0_I), .B0_F(B0_F), .B1_I(B1_I), .B1_F(B1_F), .A1_I(A1_I), .A1_F(A1_F),
    .P_I(P_I), .P_F(P_F), .S_I(S_I), .S_F(S_F), .Y_I(Y_I), .Y_F(Y_F)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .coef_b0(coef_b0), .coef_b1(coef_b1), .coef_a1(coef_a1),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // standalone requantizers for the rounding and clamping examples
  logic signed [15:0] pi_in = '0;
  logic signed [8:0]  pi_36;
  logic signed [7:0]  pi_26;
  fxq_requant #(.IN_I(3), .IN_F(13), .OUT_I(3), .OUT_F(6)) u_pi36 (.din(pi_in), .dout(pi_36));
  fxq_requant #(.IN_I(3), .IN_F(13), .OUT_I(2), .OUT_F(6)) u_pi26 (.din(pi_in), .dout(pi_26));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT && !finished) begin
      finished = 1'b1;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog R6 stream stalled actual=%0d expected<%0d", cyc, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---- arithmetic reference ----
  function automatic longint q(input longint v, input int in_f, input int oi, input int of);
    longint r, hi, lo;
    int w;
    w = oi + of;
    if (of >= in_f) r = v <<< (of - in_f);
    else            r = v >>> (in_f - of);
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  longint m_s = 0;
  longint exp_mem [0:8191];
  int wr = 0, rd = 0;

  task automatic model_push(input longint x, input longint b0, input longint b1, input longint a1);
    longint xq, b0q, b1q, a1q, p0, p1, y, pf;
    int cf;
    xq  = q(x,  IN_F, X_I,  X_F);
    b0q = q(b0, CF_F, B0_I, B0_F);
    b1q = q(b1, CF_F, B1_I, B1_F);
    a1q = q(a1, CF_F, A1_I, A1_F);
    p0  = q(xq * b0q, X_F + B0_F, P_I, P_F);
    p1  = q(xq * b1q, X_F + B1_F, P_I, P_F);
    cf  = (P_F > S_F) ? P_F : S_F;
    y   = q((p0 <<< (cf - P_F)) + (m_s <<< (cf - S_F)), cf, Y_I, Y_F);
    pf  = q(a1q * y, A1_F + Y_F, P_I, P_F);
    m_s = q(p1 - pf, P_F, S_I, S_F);
    exp_mem[wr[12:0]] = y;
    wr++;
  endtask

  function automatic logic [31:0] mix(input int a, input int b);
    logic [31:0] v;
    v = (a * 32'h9E3779B1) ^ (b * 32'h85EBCA6B) ^ 32'h1234567;
    v = v ^ (v >> 15);
    v = v * 32'h2C1B3C6D;
    v = v ^ (v >> 12);
    return v;
  endfunction

  function automatic longint s16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic gen(input int kind, input int i,
                     output longint x, output longint b0, output longint b1, output longint a1);
    logic [31:0] h, g;
    h = mix(i, kind);
    g = mix(i + 7, kind + 11);
    case (kind)
      0: begin x = (i == 0) ? 16384 : 0; b0 = 8192;   b1 = 4096;  a1 = -14746; end
      1: begin x = 32767;                 b0 = 32767;  b1 = 32767; a1 = -16000; end
      2: begin x = i[0] ? 32767 : -32768; b0 = -32768; b1 = 32767; a1 = 32767;  end
      3: begin x = s16(h[15:0]);          b0 = 12000;  b1 = -7000; a1 = 9000;   end
      default: begin
        x = s16(h[15:0]); b0 = s16(h[31:16]); b1 = s16(g[15:0]); a1 = s16(g[31:16]);
      end
    endcase
  endtask

  bit prev_stall = 1'b0;
  logic signed [13:0] prev_data = '0;

  task automatic run(input int kind, input int n, input int bp, input string tag);
    int sent = 0;
    longint x, b0, b1, a1;
    logic [31:0] r;
    bit acc;
    while ((sent < n || rd < wr) && !finished) begin
      @(negedge clk);
      r = mix(cyc, 99);
      case (bp)
        0: out_ready = 1'b1;
        1: out_ready = r[3] | r[7];
        default: out_ready = (cyc % 3 == 0);
      endcase
      if (sent < n) begin
        gen(kind, sent, x, b0, b1, a1);
        in_valid = 1'b1;
        in_data  = 16'(x);
        coef_b0  = 16'(b0);
        coef_b1  = 16'(b1);
        coef_a1  = 16'(a1);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (prev_stall) begin
        chk(out_valid == 1'b1, {tag, " R7 valid held"}, longint'(out_valid), 1);
        chk(out_data == prev_data, {tag, " R7 data held"}, longint'(out_data), longint'(prev_data));
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (rd < wr) begin
          chk(longint'(out_data) == exp_mem[rd[12:0]], tag, longint'(out_data), exp_mem[rd[12:0]]);
          rd++;
        end else begin
          chk(1'b0, {tag, " R6 extra output"}, longint'(out_data), 0);
        end
      end
      acc = in_valid && in_ready;
      if (acc) begin
        model_push(x, b0, b1, a1);
        sent++;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    prev_stall = 1'b0;
  endtask

  initial begin
    // R2 / R3: standalone requantizer examples
    pi_in = 16'sd25735;
    #1;
    chk(pi_36 == 9'sd201,  "R2 floor pi to 3.6", longint'(pi_36), 201);
    chk(pi_26 == 8'sd127,  "R3 saturate pi to 2.6", longint'(pi_26), 127);
    pi_in = -16'sd25735;
    #1;
    chk(pi_36 == -9'sd202, "R2 floor -pi to 3.6", longint'(pi_36), -202);
    chk(pi_26 == -8'sd128, "R3 saturate -pi to 2.6", longint'(pi_26), -128);

    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R8 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1,  "R8 in_ready after reset",  longint'(in_ready), 1);

    // R6: latency with the consumer always ready
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_data = 16'sd16384;
    coef_b0 = 16'sd8192; coef_b1 = 16'sd4096; coef_a1 = -16'sd8192;
    #1;
    chk(in_ready == 1'b1, "R6 accept idle", longint'(in_ready), 1);
    model_push(16384, 8192, 4096, -8192);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6 not after one edge", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid after two edges", longint'(out_valid), 1);
    chk(longint'(out_data) == exp_mem[rd[12:0]], "R6 R4 first value", longint'(out_data), exp_mem[rd[12:0]]);
    rd++;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 one output per input", longint'(out_valid), 0);

    run(0, 40,  0, "R4 impulse");
    run(1, 40,  0, "R3 positive saturation");
    run(2, 40,  0, "R3 alternating extremes");
    run(3, 600, 1, "R7 random back-pressure");
    run(4, 600, 2, "R5 per-sample coefficients");
    run(4, 300, 1, "R1 R5 full-range codes");

    // R8: reset with samples in flight
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 16'sd20000;
    coef_b0 = 16'sd9000; coef_b1 = 16'sd9000; coef_a1 = -16'sd9000;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R8 mid-run reset empties output", longint'(out_valid), 0);
    chk(in_ready == 1'b1,  "R8 mid-run reset frees input",   longint'(in_ready), 1);
    rd = wr;
    m_s = 0;
    run(0, 30, 0, "R8 zero state after reset");

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule